// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a watchdog that software must service periodically. One 32-bit service write sets three things at once: the value the timeout counter starts from, the prescaler ratio, and a reset-delay count. The counter steps down once per prescaled tick. When it expires for the first time, the block pulses an interrupt, so software gets a last chance to recover. It then reloads the counter from the reset-delay value. If that second countdown also runs out, the block raises a system reset request, which stays high until the block itself is reset.

After reset the watchdog is already counting, in its initial mode. At that point, and only then, a separate trap-door write can switch it off for good. The block waits for the next prescaler tick after that write and then parks with counting halted. A later service write starts it again. A service write made while the reset-delay countdown is running cancels the pending reset.

Top module: `wdt_twostage`

## Requirements
- R1: After reset the mode output is 0 (initial), the count is 0xFFFF, the interrupt and reset request are low, the stored reset delay is 255 and the prescaler ratio is 255.
- R2: A service write loads the count from bits 15:0, the prescaler from bits 23:16 and the reset delay from bits 31:24 of the service word. The new count is visible one clock after the write.
- R3: In modes 0 (initial) and 2 (enabled), the count falls by one every prescaler+1 clocks, counted from the last service write or from reset.
- R4: A trap-door write while in mode 0 (initial) moves the block to mode 1 (disabled) on the next clock.
- R5: A trap-door write in modes 1, 2 or 3 changes neither the mode nor the count.
- R6: The first prescaler tick in mode 1 moves the block to mode 3 (stopped). In mode 3 the count and the mode hold until the next service write.
- R7: A service write moves the block to mode 2 from any mode. It takes precedence over a trap-door write and over a tick in the same clock.
- R8: A tick that finds the count at 0 in the normal phase drives the interrupt high for exactly one clock. In that same clock the count holds the reset delay.
- R9: A tick that finds the count at 0 during the reset-delay phase raises the reset request. With a prescaler of 0 and a delay of 0, this happens one clock after the interrupt.
- R10: A service write during the reset-delay phase returns the block to the normal phase. The next expiry then produces the interrupt again, not a reset.
- R11: Once raised, the reset request stays high until the block's reset input is asserted. Until then, service writes, trap-door writes and ticks change neither the mode nor the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| svc_we | input | 1 | Service write strobe, one clock per write |
| svc_data | input | 32 | Service word: delay, prescaler, count |
| trap_we | input | 1 | Trap-door write strobe |
| wd_irq | output | 1 | One-clock interrupt pulse on the first expiry |
| wd_rst_req | output | 1 | Sticky system reset request |
| wd_state | output | 2 | Mode: 0 initial, 1 disabled, 2 enabled, 3 stopped |
| wd_count | output | 16 | Current value of the down-counter |

## Verification
The assertions take each write strobe as a plain one-clock level, sampled at the rising edge. They accept service and trap-door strobes arriving in the same clock, or in the same clock as a tick, and rely on the precedence defined above to resolve them. The stimulus changes inputs only on falling edges and applies each strobe for a single clock. It deliberately places a service write on top of a trap-door write, and on top of a due tick, so that the precedence paths are exercised inside the assumed input range.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_INIT = 2'd0,
    WD_OFF  = 2'd1,
    WD_RUN  = 2'd2,
    WD_HALT = 2'd3
  } wd_mode_e;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int PRE_W   = 8,
  parameter int RST_PRE = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [PRE_W-1:0] load_val,
  output logic             tick
);
  logic [PRE_W-1:0] scale_q, scale_d;
  logic [PRE_W-1:0] acc_q, acc_d;

  always_comb begin
    scale_d = scale_q;
    acc_d   = acc_q;
    tick    = 1'b0;
    if (load) begin
      scale_d = load_val;
      acc_d   = '0;
    end else if (run) begin
      if (acc_q == scale_q) begin
        tick  = 1'b1;
        acc_d = '0;
      end else begin
        acc_d = acc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= PRE_W'(RST_PRE);
      acc_q   <= '0;
    end else begin
      scale_q <= scale_d;
      acc_q   <= acc_d;
    end
  end

  // R3: the phase accumulator never passes the programmed ratio
  a_r3_acc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= scale_q);
endmodule

// File: rtl/wdt_mode_fsm.sv
module wdt_mode_fsm
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     svc,
  input  logic     trap,
  input  logic     tick,
  output wd_mode_e mode_q,
  output logic     counting
);
  wd_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (svc) begin
      mode_d = WD_RUN;
    end else if (trap && mode_q == WD_INIT) begin
      mode_d = WD_OFF;
    end else if (tick && mode_q == WD_OFF) begin
      mode_d = WD_HALT;
    end
  end

  assign counting = (mode_q == WD_INIT) || (mode_q == WD_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= WD_INIT;
    else        mode_q <= mode_d;
  end

  a_r7_svc_enables: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> mode_q == WD_RUN);
  a_r4_trap_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && !svc && mode_q == WD_INIT) |=> mode_q == WD_OFF);
  a_r5_trap_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && !svc && mode_q == WD_RUN) |=> mode_q == WD_RUN);
  a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == WD_HALT && !svc) |=> mode_q == WD_HALT);
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry #(
  parameter int CNT_W   = 16,
  parameter int DLY_W   = 8,
  parameter int RST_CNT = 65535,
  parameter int RST_DLY = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [DLY_W-1:0] dly_val,
  input  logic             tick,
  input  logic             counting,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q,
  output logic             rst_q,
  output logic             dly_phase_q
);
  logic [CNT_W-1:0] cnt_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             phase_d, irq_d, rst_d;
  logic             step;

  assign step = tick && counting;

  always_comb begin
    cnt_d   = cnt_q;
    dly_d   = dly_q;
    phase_d = dly_phase_q;
    irq_d   = 1'b0;
    rst_d   = rst_q;
    if (svc) begin
      cnt_d   = cnt_val;
      dly_d   = dly_val;
      phase_d = 1'b0;
    end else if (step) begin
      if (cnt_q == '0) begin
        if (dly_phase_q) begin
          rst_d = 1'b1;
        end else begin
          phase_d = 1'b1;
          irq_d   = 1'b1;
          cnt_d   = CNT_W'(dly_q);
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= CNT_W'(RST_CNT);
      dly_q       <= DLY_W'(RST_DLY);
      dly_phase_q <= 1'b0;
      irq_q       <= 1'b0;
      rst_q       <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      dly_q       <= dly_d;
      dly_phase_q <= phase_d;
      irq_q       <= irq_d;
      rst_q       <= rst_d;
    end
  end

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  a_r8_irq_in_delay: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> dly_phase_q);
  a_r9_rst_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(dly_phase_q));
  a_r11_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);
  a_r6_count_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!counting && !svc) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8,
  parameter int DLY_W   = 8,
  parameter int RST_CNT = 65535,
  parameter int RST_PRE = 255,
  parameter int RST_DLY = 255
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           svc_we,
  input  logic [CNT_W+PRE_W+DLY_W-1:0]   svc_data,
  input  logic                           trap_we,
  output logic                           wd_irq,
  output logic                           wd_rst_req,
  output logic [1:0]                     wd_state,
  output logic [CNT_W-1:0]               wd_count
);
  localparam int PRE_LSB = CNT_W;
  localparam int DLY_LSB = CNT_W + PRE_W;

  wd_mode_e mode;
  logic     counting, tick, run, svc_ok, trap_ok, dly_phase;

  assign svc_ok  = svc_we  && !wd_rst_req;
  assign trap_ok = trap_we && !wd_rst_req;
  assign run     = (mode != WD_HALT) && !wd_rst_req;

  wdt_tick_gen #(.PRE_W(PRE_W), .RST_PRE(RST_PRE)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .load     (svc_ok),
    .load_val (svc_data[PRE_LSB +: PRE_W]),
    .tick     (tick)
  );

  wdt_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc      (svc_ok),
    .trap     (trap_ok),
    .tick     (tick),
    .mode_q   (mode),
    .counting (counting)
  );

  wdt_expiry #(
    .CNT_W(CNT_W), .DLY_W(DLY_W), .RST_CNT(RST_CNT), .RST_DLY(RST_DLY)
  ) u_exp (
    .clk         (clk),
    .rst_n       (rst_n),
    .svc         (svc_ok),
    .cnt_val     (svc_data[CNT_W-1:0]),
    .dly_val     (svc_data[DLY_LSB +: DLY_W]),
    .tick        (tick),
    .counting    (counting),
    .cnt_q       (wd_count),
    .irq_q       (wd_irq),
    .rst_q       (wd_rst_req),
    .dly_phase_q (dly_phase)
  );

  assign wd_state = mode;

  // R11: after the request, the mode is frozen
  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |=> $stable(wd_state));
endmodule

// File: tb/wdt_twostage_bench.sv
`timescale 1ns/1ps
module wdt_twostage_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        svc_we = 1'b0;
  logic [31:0] svc_data = '0;
  logic        trap_we = 1'b0;
  logic        wd_irq, wd_rst_req;
  logic [1:0]  wd_state;
  logic [15:0] wd_count;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdt_twostage u_wdt_twostage (
    .clk(clk), .rst_n(rst_n), .svc_we(svc_we), .svc_data(svc_data),
    .trap_we(trap_we), .wd_irq(wd_irq), .wd_rst_req(wd_rst_req),
    .wd_state(wd_state), .wd_count(wd_count)
  );

  // behavioural reference model
  int m_state, m_cnt, m_dly, m_scale, m_pre;
  bit m_phase, m_irq, m_rst;

  always @(posedge clk or negedge rst_n) begin : m_step
    int s0;
    bit tk;
    if (!rst_n) begin
      m_state = 0; m_cnt = 16'hFFFF; m_dly = 255; m_scale = 255; m_pre = 0;
      m_phase = 0; m_irq = 0; m_rst = 0;
    end else begin
      s0 = m_state;
      m_irq = 0;
      if (svc_we && !m_rst) begin
        m_cnt = svc_data[15:0]; m_scale = svc_data[23:16]; m_dly = svc_data[31:24];
        m_pre = 0; m_phase = 0; m_state = 2;
      end else if (!m_rst) begin
        if (trap_we && s0 == 0) m_state = 1;
        if (s0 != 3) begin
          tk = (m_pre == m_scale);
          m_pre = tk ? 0 : m_pre + 1;
          if (tk) begin
            if (s0 == 1) m_state = 3;
            else if (m_cnt == 0) begin
              if (m_phase) m_rst = 1;
              else begin m_phase = 1; m_irq = 1; m_cnt = m_dly; end
            end else m_cnt = m_cnt - 1;
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 mode vs model", wd_state, m_state);
      chk("R3 count vs model", wd_count, m_cnt);
      chk("R8 irq vs model", wd_irq, m_irq);
      chk("R9 rst_req vs model", wd_rst_req, m_rst);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_svc(logic [31:0] w);
    svc_we = 1'b1; svc_data = w;
    @(negedge clk);
    svc_we = 1'b0;
  endtask

  task automatic do_trap();
    trap_we = 1'b1;
    @(negedge clk);
    trap_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; svc_we = 1'b0; trap_we = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    int k;
    int held;
    do_reset();
    chk("R1 reset mode", wd_state, 0);
    chk("R1 reset count", wd_count, 16'hFFFF);
    chk("R1 reset irq", wd_irq, 0);
    chk("R1 reset rst_req", wd_rst_req, 0);
    cyc(260);
    chk("R3 init counting", wd_count, 16'hFFFE);

    do_trap();
    chk("R4 trap in init", wd_state, 1);
    do_trap();
    chk("R5 trap in disabled", wd_state, 1);
    cyc(300);
    chk("R6 stopped after tick", wd_state, 3);
    held = wd_count;
    cyc(600);
    chk("R6 count held while stopped", wd_count, held);
    do_trap();
    chk("R5 trap in stopped", wd_state, 3);
    chk("R5 trap in stopped count", wd_count, held);

    do_svc(32'h0302_0005);
    chk("R7 service enables", wd_state, 2);
    chk("R2 count field", wd_count, 5);
    cyc(3);
    chk("R3 step after prescale+1", wd_count, 4);
    cyc(3);
    chk("R3 second step", wd_count, 3);
    do_trap();
    chk("R5 trap in enabled", wd_state, 2);
    k = 0;
    while (!wd_irq && k < 100) begin cyc(1); k++; end
    chk("R8 irq raised", wd_irq, 1);
    chk("R8 count holds delay", wd_count, 3);
    cyc(1);
    chk("R8 irq single clock", wd_irq, 0);

    do_svc(32'h0302_0002);
    k = 0;
    while (!wd_irq && !wd_rst_req && k < 100) begin cyc(1); k++; end
    chk("R10 irq again after cancel", wd_irq, 1);
    chk("R10 no reset after cancel", wd_rst_req, 0);
    k = 0;
    while (!wd_rst_req && k < 100) begin cyc(1); k++; end
    chk("R9 reset after delay", wd_rst_req, 1);
    chk("R9 delay length", k, 12);

    do_svc(32'h0101_0010);
    chk("R11 sticky after service", wd_rst_req, 1);
    chk("R11 count frozen", wd_count, 0);
    chk("R11 mode frozen", wd_state, 2);
    do_trap();
    cyc(20);
    chk("R11 still requesting", wd_rst_req, 1);

    do_reset();
    do_svc(32'h0000_0000);
    cyc(1);
    chk("R8 zero-delay irq", wd_irq, 1);
    chk("R8 zero-delay count", wd_count, 0);
    cyc(1);
    chk("R9 reset one clock after irq", wd_rst_req, 1);

    do_reset();
    trap_we = 1'b1;
    do_svc(32'h0000_0010);
    trap_we = 1'b0;
    chk("R7 service beats trap", wd_state, 2);

    do_reset();
    do_trap();
    do_svc(32'h0000_0007);
    chk("R7 service from disabled", wd_state, 2);
    do_svc(32'h0000_0007);
    chk("R7 service beats tick", wd_count, 7);
    do_trap();
    chk("R5 trap ignored after service", wd_state, 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule